// File: doc/BRIEF.md
# Five-State Snooping Line Coherence Controller

This block keeps the coherence state of a small bank of lines for one private cache on a broadcast snooping bus. There are five line states: Invalid, Shared, Exclusive, Modified, and a designated-responder state called Forward. Each cycle the block can take one local load or store from the core and one snooped bus command. It produces the bus request that the local access needs, the data-supply and writeback indications for the snooped command, and a shared signal back to the bus. The state of every tracked line is visible at the ports.

When several caches share a line, the Forward copy is the only one that answers a snooped read. When it answers, it drops to Shared, and the requester installs the line in Forward. As a result, the responder role always moves to the newest reader. Shared copies stay silent. Modified and Exclusive lines are read and written with no bus traffic. Bus arbitration and the data array belong to the surrounding logic. A local read miss samples the bus shared input in the same cycle as its request.

Top module: `mesif_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and no bus request, supply, writeback or shared indication is asserted.
- R2: A granted local read of an Invalid line issues a bus read (command code 0). The line becomes Forward if the bus shared input is high in that cycle, and Exclusive otherwise.
- R3: Granted local reads of Shared, Forward, Exclusive or Modified lines, and granted local writes of Exclusive or Modified lines, issue no bus request. A write moves the line to Modified.
- R4: A granted local write issues a bus invalidate (code 2) from Shared or Forward, and a read-for-ownership (code 1) from Invalid. In every case the line becomes Modified.
- R5: For a snooped read (code 0), a Modified, Exclusive or Forward line supplies data and becomes Shared, and only a Modified line also signals writeback. A Shared line supplies nothing and stays Shared, and an Invalid line stays Invalid.
- R6: For a snooped read-for-ownership (code 1) or invalidate (code 2), every line goes Invalid and a Modified line supplies data with writeback. For read-for-ownership, Exclusive and Forward lines also supply data.
- R7: The shared output is high exactly when a snooped read finds its line in any state other than Invalid.
- R8: If an active snoop targets the same line as a local request, the snoop wins: the local request is not granted, issues no bus request and changes no state. Different lines are both served in the same cycle.
- R9: Snoop command code 3 is a no-operation. It produces no supply, writeback or shared indication, changes no line, and blocks no local request.
- R10: The state output packs line i into bits [3i+2:3i], encoded Invalid=0, Shared=1, Exclusive=2, Modified=3, Forward=4, and never holds any other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| locValid | input | 1 | Local access request |
| locWrite | input | 1 | Local access is a store |
| locIdx | input | IDXW | Line addressed by the local access |
| locGrant | output | 1 | Local access accepted this cycle |
| busReqValid | output | 1 | Bus request issued for the local access |
| busReqCmd | output | 2 | Bus request code: 0 read, 1 read-for-ownership, 2 invalidate |
| busShared | input | 1 | Another cache holds the line requested by a local read miss |
| snpValid | input | 1 | Snooped command present |
| snpCmd | input | 2 | Snooped command code: 0 read, 1 read-for-ownership, 2 invalidate, 3 no-op |
| snpIdx | input | IDXW | Line addressed by the snoop |
| snpSupply | output | 1 | This cache supplies the line's data |
| snpWriteback | output | 1 | Supplied data is dirty and must be written back |
| snpSharedOut | output | 1 | This cache holds the snooped line |
| lineStates | output | 3*NUM_LINES | Packed state of all lines |

## Verification
A wrong stored state shows at the ports in two ways. The packed state output shows it one cycle after the access that caused it. The next access to that line then shows it again: a line wrongly left Exclusive hides the bus invalidate a later store needs, and a line wrongly kept Forward supplies data a second time on the next snooped read. Random mixed local and snooped traffic is compared cycle by cycle against a reference model. This catches both the immediate output error and the latent state error within the cycle after the next access to the same line.

// File: rtl/mesif_pkg.sv
`timescale 1ns/1ps
package mesif_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_M = 3'd3,
    ST_F = 3'd4
  } lineState_e;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_RFO = 2'd1,
    CMD_INV = 2'd2,
    CMD_NOP = 2'd3
  } busCmd_e;

  // strobes from control to the state bank
  typedef struct packed {
    logic       snpWr;
    lineState_e snpNext;
    logic       locWr;
    lineState_e locNext;
  } strobe_t;

  localparam int STATE_W = 3;
endpackage

// File: rtl/mesif_line_bank.sv
`timescale 1ns/1ps
module mesif_line_bank
  import mesif_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int IDXW      = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strb,
  input  logic [IDXW-1:0]              snpIdx,
  input  logic [IDXW-1:0]              locIdx,
  output lineState_e                   snpState,
  output lineState_e                   locState,
  output logic [STATE_W*NUM_LINES-1:0] lineStates
);
  lineState_e st [NUM_LINES];

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_line
      logic snpHere;
      logic locHere;
      assign snpHere = strb.snpWr && (snpIdx == IDXW'(g));
      assign locHere = strb.locWr && (locIdx == IDXW'(g));

      // snoop update takes precedence on a shared index
      always_ff @(posedge clk) begin
        if (!rstN)        st[g] <= ST_I;
        else if (snpHere) st[g] <= strb.snpNext;
        else if (locHere) st[g] <= strb.locNext;
      end

      assign lineStates[g*STATE_W +: STATE_W] = st[g];
    end
  endgenerate

  always_comb begin
    snpState = ST_I;
    locState = ST_I;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (snpIdx == IDXW'(i)) snpState = st[i];
      if (locIdx == IDXW'(i)) locState = st[i];
    end
  end
endmodule

// File: rtl/mesif_ctrl.sv
`timescale 1ns/1ps
module mesif_ctrl
  import mesif_pkg::*;
#(
  parameter int IDXW = 2
) (
  input  logic            locValid,
  input  logic            locWrite,
  input  logic [IDXW-1:0] locIdx,
  input  logic            snpValid,
  input  logic [1:0]      snpCmd,
  input  logic [IDXW-1:0] snpIdx,
  input  lineState_e      snpState,
  input  lineState_e      locState,
  input  logic            busShared,
  output strobe_t         strb,
  output logic            locGrant,
  output logic            busReqValid,
  output logic [1:0]      busReqCmd,
  output logic            snpSupply,
  output logic            snpWriteback,
  output logic            snpSharedOut
);
  logic    snpAct;
  busCmd_e cmd;

  assign cmd    = busCmd_e'(snpCmd);
  assign snpAct = snpValid && (cmd != CMD_NOP);

  // snoop side
  always_comb begin
    strb.snpWr    = snpAct;
    strb.snpNext  = snpState;
    snpSupply     = 1'b0;
    snpWriteback  = 1'b0;
    snpSharedOut  = 1'b0;
    if (snpAct) begin
      unique case (cmd)
        CMD_RD: begin
          snpSharedOut = (snpState != ST_I);
          unique case (snpState)
            ST_M: begin
              snpSupply    = 1'b1;
              snpWriteback = 1'b1;
              strb.snpNext = ST_S;
            end
            ST_E, ST_F: begin
              snpSupply    = 1'b1;
              strb.snpNext = ST_S;
            end
            default: strb.snpNext = snpState;
          endcase
        end
        CMD_RFO, CMD_INV: begin
          strb.snpNext = ST_I;
          if (snpState == ST_M) begin
            snpSupply    = 1'b1;
            snpWriteback = 1'b1;
          end else if (cmd == CMD_RFO && (snpState == ST_E || snpState == ST_F)) begin
            snpSupply = 1'b1;
          end
        end
        default: strb.snpNext = snpState;
      endcase
    end
  end

  // local side
  always_comb begin
    locGrant     = locValid && !(snpAct && (snpIdx == locIdx));
    strb.locWr   = locGrant;
    strb.locNext = locState;
    busReqValid  = 1'b0;
    busReqCmd    = CMD_RD;
    if (locGrant) begin
      if (locWrite) begin
        strb.locNext = ST_M;
        unique case (locState)
          ST_I: begin
            busReqValid = 1'b1;
            busReqCmd   = CMD_RFO;
          end
          ST_S, ST_F: begin
            busReqValid = 1'b1;
            busReqCmd   = CMD_INV;
          end
          default: busReqValid = 1'b0;
        endcase
      end else if (locState == ST_I) begin
        busReqValid  = 1'b1;
        busReqCmd    = CMD_RD;
        strb.locNext = busShared ? ST_F : ST_E;
      end
    end
  end
endmodule

// File: rtl/mesif_snoop_ctrl.sv
`timescale 1ns/1ps
module mesif_snoop_ctrl
  import mesif_pkg::*;
#(
  parameter int NUM_LINES = 4,
  localparam int IDXW     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         locValid,
  input  logic                         locWrite,
  input  logic [IDXW-1:0]              locIdx,
  output logic                         locGrant,
  output logic                         busReqValid,
  output logic [1:0]                   busReqCmd,
  input  logic                         busShared,
  input  logic                         snpValid,
  input  logic [1:0]                   snpCmd,
  input  logic [IDXW-1:0]              snpIdx,
  output logic                         snpSupply,
  output logic                         snpWriteback,
  output logic                         snpSharedOut,
  output logic [STATE_W*NUM_LINES-1:0] lineStates
);
  strobe_t    strb;
  lineState_e snpState;
  lineState_e locState;

  mesif_line_bank #(.NUM_LINES(NUM_LINES), .IDXW(IDXW)) i_bank (
    .clk(clk), .rstN(rstN), .strb(strb),
    .snpIdx(snpIdx), .locIdx(locIdx),
    .snpState(snpState), .locState(locState),
    .lineStates(lineStates)
  );

  mesif_ctrl #(.IDXW(IDXW)) i_ctrl (
    .locValid(locValid), .locWrite(locWrite), .locIdx(locIdx),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpIdx(snpIdx),
    .snpState(snpState), .locState(locState), .busShared(busShared),
    .strb(strb), .locGrant(locGrant),
    .busReqValid(busReqValid), .busReqCmd(busReqCmd),
    .snpSupply(snpSupply), .snpWriteback(snpWriteback),
    .snpSharedOut(snpSharedOut)
  );
endmodule

// File: rtl/mesif_snoop_ctrl_chk.sv
`timescale 1ns/1ps
module mesif_snoop_ctrl_chk #(
  parameter int NUM_LINES = 4,
  localparam int IDXW     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   locValid,
  input logic                   locWrite,
  input logic [IDXW-1:0]        locIdx,
  input logic                   locGrant,
  input logic                   busReqValid,
  input logic [1:0]             busReqCmd,
  input logic                   busShared,
  input logic                   snpValid,
  input logic [1:0]             snpCmd,
  input logic [IDXW-1:0]        snpIdx,
  input logic                   snpSupply,
  input logic                   snpWriteback,
  input logic                   snpSharedOut,
  input logic [3*NUM_LINES-1:0] lineStates
);
  function automatic logic [2:0] stAt(input logic [3*NUM_LINES-1:0] v, input logic [IDXW-1:0] i);
    return v[i*3 +: 3];
  endfunction

  logic anyIllegal;
  always_comb begin
    anyIllegal = 1'b0;
    for (int i = 0; i < NUM_LINES; i++)
      if (lineStates[i*3 +: 3] > 3'd4) anyIllegal = 1'b1;
  end

  p_legal_code_r10: assert property (@(posedge clk) disable iff (!rstN) !anyIllegal);

  p_wb_with_supply_r6: assert property (@(posedge clk) disable iff (!rstN)
    snpWriteback |-> snpSupply);

  p_read_demotes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpCmd == 2'd0) |=>
      (stAt(lineStates, $past(snpIdx)) == 3'd1 || stAt(lineStates, $past(snpIdx)) == 3'd0));

  p_kill_invalid_r6: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && (snpCmd == 2'd1 || snpCmd == 2'd2)) |=> stAt(lineStates, $past(snpIdx)) == 3'd0);

  p_write_to_m_r4: assert property (@(posedge clk) disable iff (!rstN)
    (locGrant && locWrite) |=> stAt(lineStates, $past(locIdx)) == 3'd3);

  p_conflict_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (locValid && snpValid && snpCmd != 2'd3 && snpIdx == locIdx) |-> !locGrant);

  p_req_needs_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid |-> (locGrant && busReqCmd != 2'd3));

  p_shared_only_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    snpSharedOut |-> (snpValid && snpCmd == 2'd0));

  p_nop_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpCmd == 2'd3) |-> (!snpSupply && !snpWriteback && !snpSharedOut));
endmodule

bind mesif_snoop_ctrl mesif_snoop_ctrl_chk #(.NUM_LINES(NUM_LINES)) i_chk (.*);

// File: tb/test_mesif_snoop_ctrl.sv
`timescale 1ns/1ps
module test_mesif_snoop_ctrl;
  localparam int NL = 4;
  localparam int IW = 2;
  localparam logic [2:0] I = 3'd0, S = 3'd1, E = 3'd2, M = 3'd3, F = 3'd4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic locValid = 0, locWrite = 0, busShared = 0, snpValid = 0;
  logic [IW-1:0] locIdx = '0, snpIdx = '0;
  logic [1:0] snpCmd = '0;
  logic locGrant, busReqValid, snpSupply, snpWriteback, snpSharedOut;
  logic [1:0] busReqCmd;
  logic [3*NL-1:0] lineStates;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [2:0] mdl [NL];

  always #4 clk = ~clk;

  mesif_snoop_ctrl #(.NUM_LINES(NL)) i_mesif_snoop_ctrl (
    .clk(clk), .rstN(rstN), .locValid(locValid), .locWrite(locWrite), .locIdx(locIdx),
    .locGrant(locGrant), .busReqValid(busReqValid), .busReqCmd(busReqCmd),
    .busShared(busShared), .snpValid(snpValid), .snpCmd(snpCmd), .snpIdx(snpIdx),
    .snpSupply(snpSupply), .snpWriteback(snpWriteback), .snpSharedOut(snpSharedOut),
    .lineStates(lineStates)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3*NL-1:0] mdlFlat();
    logic [3*NL-1:0] v;
    for (int i = 0; i < NL; i++) v[i*3 +: 3] = mdl[i];
    return v;
  endfunction

  function automatic logic expSupply(input logic [2:0] st, input logic [1:0] c);
    if (c == 2'd0 || c == 2'd1) return (st == M || st == E || st == F);
    if (c == 2'd2) return (st == M);
    return 1'b0;
  endfunction

  function automatic logic [2:0] expSnpNext(input logic [2:0] st, input logic [1:0] c);
    if (c == 2'd0) return (st == I) ? I : S;
    if (c == 2'd3) return st;
    return I;
  endfunction

  task automatic doOp(input logic lv, input logic lw, input logic [IW-1:0] li,
                      input logic sv, input logic [1:0] sc, input logic [IW-1:0] si,
                      input logic sh);
    logic act, g, bv;
    logic [1:0] bc;
    logic [2:0] ls, ss, ln;
    string bt, st;
    @(negedge clk);
    locValid = lv; locWrite = lw; locIdx = li;
    snpValid = sv; snpCmd = sc; snpIdx = si; busShared = sh;
    #1;
    act = sv && sc != 2'd3;
    ss  = mdl[si];
    ls  = mdl[li];
    g   = lv && !(act && si == li);
    bv = 0; bc = 2'd0; ln = ls;
    bt = lw ? ((ls == E || ls == M) ? "R3" : "R4") : ((ls == I) ? "R2" : "R3");
    if (g) begin
      if (lw) begin
        ln = M;
        if (ls == I) begin bv = 1; bc = 2'd1; end
        else if (ls == S || ls == F) begin bv = 1; bc = 2'd2; end
      end else if (ls == I) begin
        bv = 1; bc = 2'd0; ln = sh ? F : E;
      end
    end
    st = (!sv || sc == 2'd3) ? "R9" : (sc == 2'd0 ? "R5" : "R6");
    chk("R8", "locGrant", locGrant, g);
    chk(bt, "busReqValid", busReqValid, bv);
    if (bv) chk(bt, "busReqCmd", busReqCmd, bc);
    chk(st, "snpSupply", snpSupply, act && expSupply(ss, sc));
    chk(st, "snpWriteback", snpWriteback, act && ss == M);
    chk("R7", "snpSharedOut", snpSharedOut, act && sc == 2'd0 && ss != I);
    @(posedge clk);
    #1;
    if (g) mdl[li] = ln;
    if (act) mdl[si] = expSnpNext(ss, sc);
    chk("R10", "lineStates", lineStates, mdlFlat());
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) mdl[i] = I;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "lineStates", lineStates, '0);
    chk("R1", "busReqValid", busReqValid, 0);
    chk("R1", "snpSupply", snpSupply, 0);
    chk("R1", "snpSharedOut", snpSharedOut, 0);

    doOp(1, 0, 0, 0, 0, 0, 0);      // R2 miss alone -> E
    doOp(1, 1, 0, 0, 0, 0, 0);      // R3 E write silent -> M
    doOp(0, 0, 0, 1, 2'd0, 0, 0);   // R5 snoop read of M
    doOp(1, 0, 0, 0, 0, 0, 0);      // R3 S read silent
    doOp(1, 1, 0, 0, 0, 0, 0);      // R4 S write -> invalidate
    doOp(0, 0, 0, 1, 2'd1, 0, 0);   // R6 rfo of M
    doOp(1, 0, 1, 0, 0, 0, 1);      // R2 miss shared -> F
    doOp(0, 0, 0, 1, 2'd0, 1, 0);   // R5 F supplies
    doOp(0, 0, 0, 1, 2'd0, 1, 0);   // R5 R7 S silent but shared
    doOp(1, 1, 2, 0, 0, 0, 0);      // R4 rfo miss
    doOp(0, 0, 0, 1, 2'd2, 2, 0);   // R6 invalidate of M
    doOp(1, 1, 3, 1, 2'd0, 3, 0);   // R8 conflict
    doOp(1, 1, 3, 0, 0, 0, 0);
    doOp(1, 0, 3, 1, 2'd3, 3, 0);   // R9 nop does not block or touch
    doOp(1, 0, 1, 1, 2'd0, 3, 1);   // R8 different lines both served

    void'($urandom(32'd4242));
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] r;
      r = $urandom;
      doOp(r[0], r[1], r[3:2], r[4] | r[5], r[7:6], r[9:8], r[10]);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule